// File: doc/BRIEF.md
# Timer Channel Status Flags

This block holds the status byte of one channel of a 16-bit up/down timer. It tracks the counting direction and keeps four sticky event flags: counter wrap downward, counter wrap upward, and one capture/compare flag for each of the two general registers of the channel, called A and B. The counter and the general registers sit outside the block. The block only watches the counter value, its direction, and the compare-match and capture strobes that the neighbouring logic produces.

Software clears a flag in two steps. It first reads the byte while the flag is 1, and then writes 0 to that bit. A write of 1 does nothing, and a write of 0 does nothing unless the flag was read as 1 first. A transfer controller serving the A or B interrupt can also clear the matching flag, but only under two qualifiers. A setting event always beats a clear in the same cycle. Each flag drives an interrupt request that is gated by its own enable input.

Top module: `tsr_top`

## Requirements
- R1: Bit 7 of `rd_data` shows the direction input `cnt_up` as registered on the previous clock edge (1 = counting up). It resets to 1, and writes do not change it.
- R2: Bit 6 (underflow) becomes 1 on the edge after the counter moves from 0x0000 to 0xFFFF between two consecutive edges.
- R3: Bit 5 (overflow) becomes 1 on the edge after the counter moves from 0xFFFF to 0x0000 between two consecutive edges.
- R4: Bit 4 always reads 1 and bits 3:2 always read 0. After reset `rd_data` is 0x90 and `irq` is 0.
- R5: Bit 0 (flag A) and bit 1 (flag B) each sit in one of two modes, picked by `cap_mode[0]` for A and `cap_mode[1]` for B. In compare mode (mode bit 0), the flag is set by its compare strobe (`cmp_hit[0]` for A, `cmp_hit[1]` for B), and its capture strobe is ignored.
- R6: In capture mode (mode bit 1), the flag is set by its capture strobe (`cap_hit[0]` for A, `cap_hit[1]` for B), and its compare strobe is ignored.
- R7: Writing 0 to a flag bit (bits 6, 5, 1, 0) clears that flag only if the most recent access to the register before the write was a read that saw the flag as 1. Every write uses up this arming, so a second write of 0 needs a new read.
- R8: Writing 1 to a flag bit leaves the flag unchanged.
- R9: If a setting event and a clear happen on the same edge, the flag stays 1.
- R10: A transfer clear request (`xfer_clr[0]` for A, `xfer_clr[1]` for B) clears that flag only when `xfer_dis_sel` is 0 and `xfer_cnt_zero` is 0.
- R11: `irq` equals {underflow, overflow, B, A} ANDed bit by bit with `irq_en`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 16 | Current counter value |
| cnt_up | input | 1 | Counter direction, 1 = up |
| cap_mode | input | 2 | Per general register: 1 = capture mode, 0 = compare mode ([0]=A, [1]=B) |
| cmp_hit | input | 2 | Compare-match strobes ([0]=A, [1]=B) |
| cap_hit | input | 2 | Capture strobes ([0]=A, [1]=B) |
| reg_rd | input | 1 | CPU read strobe for the status byte |
| reg_wr | input | 1 | CPU write strobe for the status byte |
| reg_wdata | input | 8 | CPU write data |
| xfer_clr | input | 2 | Transfer-controller clear requests ([0]=A, [1]=B) |
| xfer_dis_sel | input | 1 | Transfer controller disable-interrupt select bit |
| xfer_cnt_zero | input | 1 | Transfer count has reached zero |
| irq_en | input | 4 | Interrupt enables {underflow, overflow, B, A} |
| rd_data | output | 8 | Status byte read value |
| irq | output | 4 | Interrupt requests {underflow, overflow, B, A} |

## Verification
The bench tries to clear flags with a write of 0 that has no read before it, with a write of 1, and with a second write of 0 after the arming has been used up. A design that cleared on any write of 0, or that kept the arming after a write, would drop those flags. It fires a capture strobe at a register that is in compare mode, and a compare strobe at one that is in capture mode. A design that decoded the mode wrongly would set the flag. It also sends a setting event in the same cycle as an armed clear, and sends transfer clears with each qualifier blocking in turn. A wrong priority or a wrong qualifier would leave a flag cleared that should still be set, or set when it should be cleared.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
    localparam int CNT_W = 16;
    localparam int NFLAG = 4;

    // flag index order also defines irq / irq_en bit order
    localparam int IX_A   = 0;
    localparam int IX_B   = 1;
    localparam int IX_OVF = 2;
    localparam int IX_UNF = 3;

    // status byte bit that carries each flag
    function automatic int flag_bit(input int ix);
        case (ix)
            IX_A:    return 0;
            IX_B:    return 1;
            IX_OVF:  return 5;
            default: return 6;
        endcase
    endfunction

    typedef struct packed {
        logic flag;
        logic arm;
    } cell_st_t;

    typedef struct packed {
        logic             dir;
        logic             vld;
        logic [CNT_W-1:0] prev;
    } top_st_t;
endpackage

// File: rtl/tsr_evt.sv
module tsr_evt #(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt_val,
    input  logic [W-1:0] cnt_prev,
    input  logic         prev_vld,
    input  logic [1:0]   cap_mode,
    input  logic [1:0]   cmp_hit,
    input  logic [1:0]   cap_hit,
    output logic [3:0]   set_ev
);
    localparam logic [W-1:0] ALL1 = {W{1'b1}};
    localparam logic [W-1:0] ALL0 = '0;

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_gr
            assign set_ev[g] = cap_mode[g] ? cap_hit[g] : cmp_hit[g];
        end
    endgenerate

    assign set_ev[2] = prev_vld && (cnt_prev == ALL1) && (cnt_val == ALL0);
    assign set_ev[3] = prev_vld && (cnt_prev == ALL0) && (cnt_val == ALL1);
endmodule

// File: rtl/tsr_flag_cell.sv
module tsr_flag_cell
    import tsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wr_zero_i,
    input  logic xclr_i,
    output logic flag_o
);
    cell_st_t st_d, st_q;
    logic     clr;

    always_comb begin
        st_d = st_q;
        if (rd_i)
            st_d.arm = st_q.flag;
        else if (wr_i)
            st_d.arm = 1'b0;
        clr = (wr_zero_i && st_q.arm) || xclr_i;
        if (set_i)
            st_d.flag = 1'b1;
        else if (clr)
            st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    a_r7_no_clear_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !st_q.arm && !xclr_i) |=> flag_o);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !(wr_zero_i && st_q.arm) && !xclr_i) |=> flag_o);

    a_r10_xfer_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (xclr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/tsr_top.sv
module tsr_top
    import tsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_up,
    input  logic [1:0]       cap_mode,
    input  logic [1:0]       cmp_hit,
    input  logic [1:0]       cap_hit,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    input  logic [1:0]       xfer_clr,
    input  logic             xfer_dis_sel,
    input  logic             xfer_cnt_zero,
    input  logic [NFLAG-1:0] irq_en,
    output logic [7:0]       rd_data,
    output logic [NFLAG-1:0] irq
);
    top_st_t          st_d, st_q;
    logic [NFLAG-1:0] set_ev;
    logic [NFLAG-1:0] flags;
    logic [NFLAG-1:0] xclr;
    logic             xfer_ok;

    always_comb begin
        st_d      = st_q;
        st_d.dir  = cnt_up;
        st_d.vld  = 1'b1;
        st_d.prev = cnt_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dir  <= 1'b1;
            st_q.vld  <= 1'b0;
            st_q.prev <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    tsr_evt #(.W(CNT_W)) u_evt (
        .cnt_val  (cnt_val),
        .cnt_prev (st_q.prev),
        .prev_vld (st_q.vld),
        .cap_mode (cap_mode),
        .cmp_hit  (cmp_hit),
        .cap_hit  (cap_hit),
        .set_ev   (set_ev)
    );

    assign xfer_ok = !xfer_dis_sel && !xfer_cnt_zero;

    genvar g;
    generate
        for (g = 0; g < NFLAG; g++) begin : g_flag
            localparam int BP = flag_bit(g);
            if (g < 2) begin : g_xc
                assign xclr[g] = xfer_clr[g] && xfer_ok;
            end else begin : g_nx
                assign xclr[g] = 1'b0;
            end
            tsr_flag_cell u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .set_i     (set_ev[g]),
                .rd_i      (reg_rd),
                .wr_i      (reg_wr),
                .wr_zero_i (reg_wr && !reg_wdata[BP]),
                .xclr_i    (xclr[g]),
                .flag_o    (flags[g])
            );
        end
    endgenerate

    assign rd_data = {st_q.dir, flags[IX_UNF], flags[IX_OVF], 1'b1, 2'b00,
                      flags[IX_B], flags[IX_A]};
    assign irq     = flags & irq_en;

    a_r1_dir: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rd_data[7] == $past(cnt_up)));

    a_r3_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && st_q.prev == {CNT_W{1'b1}} && cnt_val == '0) |=> rd_data[5]);

    a_r2_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && st_q.prev == '0 && cnt_val == {CNT_W{1'b1}}) |=> rd_data[6]);

    a_r10_qualifier: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[0] && (xfer_dis_sel || xfer_cnt_zero) && !reg_wr) |=> rd_data[0]);
endmodule

// File: tb/tb_tsr_top.sv
`timescale 1ns/1ps
module tb_tsr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_val = 16'h0010;
    logic        cnt_up = 1'b1;
    logic [1:0]  cap_mode = 2'b10;
    logic [1:0]  cmp_hit = '0, cap_hit = '0, xfer_clr = '0;
    logic        reg_rd = 0, reg_wr = 0, xfer_dis_sel = 0, xfer_cnt_zero = 0;
    logic [7:0]  reg_wdata = '0;
    logic [3:0]  irq_en = 4'hF;
    logic [7:0]  rd_data;
    logic [3:0]  irq;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    tsr_top dut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_up(cnt_up),
        .cap_mode(cap_mode), .cmp_hit(cmp_hit), .cap_hit(cap_hit),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .xfer_clr(xfer_clr), .xfer_dis_sel(xfer_dis_sel),
        .xfer_cnt_zero(xfer_cnt_zero), .irq_en(irq_en),
        .rd_data(rd_data), .irq(irq)
    );

    typedef struct packed {
        logic [15:0] cnt;
        logic        up, cma, cmb, cpa, cpb, rd, wr;
        logic [7:0]  wd;
        logic [7:0]  exp;
        logic [3:0]  req;
    } row_t;

    // A in compare mode, B in capture mode
    localparam row_t TBL [16] = '{
        '{16'h0011, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h90, 4'd4}, // R4
        '{16'h0012, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h10, 4'd1}, // R1
        '{16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h10, 4'd2}, // R2
        '{16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h50, 4'd2}, // R2
        '{16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hF0, 4'd3}, // R3
        '{16'h0001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hF1, 4'd5}, // R5
        '{16'h0001, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hF1, 4'd5}, // R5 R6
        '{16'h0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'hF3, 4'd6}, // R6
        '{16'h0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'hF3, 4'd7}, // R7
        '{16'h0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'hF3, 4'd7}, // R7
        '{16'h0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'hF3, 4'd8}, // R8
        '{16'h0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'hF3, 4'd7}, // R7
        '{16'h0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hDE, 8'hD2, 4'd7}, // R7
        '{16'h0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'hD2, 4'd7}, // R7
        '{16'h0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'hD2, 4'd9}, // R9
        '{16'h0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h92, 4'd9}  // R9
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cmp_hit = '0; cap_hit = '0; reg_rd = 0; reg_wr = 0; xfer_clr = '0;
    endtask

    initial begin
        #(200000 * 8);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R4 reset rd_data", rd_data, 8'h90);
        chk("R4 reset irq", {4'h0, irq}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 16; i++) begin
            cnt_val = TBL[i].cnt; cnt_up = TBL[i].up;
            cmp_hit = {TBL[i].cmb, TBL[i].cma};
            cap_hit = {TBL[i].cpb, TBL[i].cpa};
            reg_rd = TBL[i].rd; reg_wr = TBL[i].wr; reg_wdata = TBL[i].wd;
            tick();
            chk($sformatf("R%0d table row %0d", TBL[i].req, i), rd_data, TBL[i].exp);
        end

        // R11: state now B=1, others 0
        irq_en = 4'b0010; #1;
        chk("R11 irq B enabled", {4'h0, irq}, 8'h02);
        irq_en = 4'b1101; #1;
        chk("R11 irq B masked", {4'h0, irq}, 8'h00);
        irq_en = 4'hF;

        // R10: transfer clear qualifiers
        cmp_hit = 2'b01; tick();
        chk("R10 A set", rd_data, 8'h93);
        xfer_clr = 2'b01; xfer_dis_sel = 1; xfer_cnt_zero = 0; tick();
        chk("R10 blocked by dis_sel", rd_data, 8'h93);
        xfer_clr = 2'b01; xfer_dis_sel = 0; xfer_cnt_zero = 1; tick();
        chk("R10 blocked by cnt zero", rd_data, 8'h93);
        xfer_clr = 2'b01; xfer_cnt_zero = 0; tick();
        chk("R10 clears A", rd_data, 8'h92);
        xfer_clr = 2'b10; tick();
        chk("R10 clears B", rd_data, 8'h90);

        // R4: reset in mid run
        cap_hit = 2'b10; cnt_up = 0; tick();
        chk("R6 B set again", rd_data, 8'h12);
        rst_n = 0; #1;
        chk("R4 async reset rd_data", rd_data, 8'h90);
        chk("R4 async reset irq", {4'h0, irq}, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule